// File: doc/BRIEF.md
# Sigma-Delta Decimation Controller

This block is the digital back end of a first-order sigma-delta converter. A one-bit modulator stream arrives with a 1 MHz sample strobe. The block filters that stream with a second-order integrate-and-dump decimator and writes each result, left-justified, into a 16-bit data register. A single 3-bit rate code sets both the conversion time and the number of valid result bits. Every step of the code doubles the conversion window and adds one bit of resolution.

Software uses a small register port to select the analog input, pick the rate and set the enable bit. While enabled, the block converts back to back. It raises a completion flag after each conversion. The flag stays set until software writes a one to it. It reaches the interrupt line only when its mask bit is set. The decimator is pipelined, so the first result after enabling is incomplete, and a status bit marks it as invalid. The selected input code is driven straight out to an external analog multiplexer.

The input-select codes are:
- 0 to 3: single-ended channels
- 4: a quarter of the pad supply
- 5: half of the core supply
- 6: reserved
- 7: ground
- 8: the reference
- 9 and 10: the two differential pairs

Top module: `sdm_decim_ctrl`

## Requirements
- R1: After reset, all of the following read zero: every register, `irq` and `amux_sel`.
- R2: The conversion window is 32·2^R strobe samples, where R is the rate code. When the enable bit is set, the sample count restarts from zero. Completions then fall on strobe samples N, 2N, 3N and so on (N = 32·2^R), with no gap between conversions.
- R3: Consider a valid result for a periodic input of period 32 with k ones per period (k < 32). Its 5+R-bit value is k·2^R. This value is placed at data bits [15:11−R], and the bits below 11−R read zero. Data is at address 2.
- R4: A full-scale input (all ones) saturates to 2^(5+R)−1. This value is left-justified as in R3.
- R5: Each completion sets the flag (address 1 bit 0). Writing 1 to that bit clears it, but a completion in the same cycle wins and the flag stays set. The mask is address 1 bit 1. `irq` is high only when both the flag and the mask are set.
- R6: The invalid status bit (address 3 bit 0) is set when the block is enabled. It is still set when the first completion is reported. It clears when the second completion arrives.
- R7: The configuration register is address 0: enable in bit 0, rate in bits [3:1], select in bits [7:4]. While enabled, writes leave the rate and select unchanged. `amux_sel` always shows the stored select code. Clearing the enable bit stops conversions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-cycle strobe at the 1 MHz modulator rate |
| bit_in | input | 1 | Modulator output bit, valid with `sample_stb` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Masked completion interrupt |
| amux_sel | output | 4 | Input-select code to the analog multiplexer |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the exact clock edge where a completion also happens. The bench drives the sample strobe itself and counts strobes from the enabling write. It places the clear write in the same cycle as strobe number 2N, then checks that the flag survives. Result values are checked with random 32-sample patterns of known ones density. For these patterns the decimator output is exact, so each valid result must equal k·2^R, or the saturated value at full scale.

// File: rtl/sdm_decim_ctrl.sv
module sdm_decim_ctrl #(
  parameter int WIN_LG = 5,
  parameter int RATE_W = 3,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_stb,
  input  logic                    bit_in,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [RATE_W+SEL_W:0]   wr_data,
  input  logic [1:0]              rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    irq,
  output logic [SEL_W-1:0]        amux_sel
);
  localparam int MAX_R   = (1 << RATE_W) - 1;
  localparam int CNT_W   = WIN_LG + MAX_R;
  localparam int ACC_W   = 2 * CNT_W + 1;
  localparam int RATE_LO = 1;
  localparam int SEL_LO  = 1 + RATE_W;

  logic                en_q, flag_q, mask_q, inval_q, seen_one_q;
  logic [RATE_W-1:0]   rate_q;
  logic [SEL_W-1:0]    sel_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ACC_W-1:0]    int1_q, int2_q, dly1_q, dly2_q;
  logic [DATA_W-1:0]   data_q;

  wire wr_cfg = wr_en && (wr_addr == 2'd0);
  wire wr_irq = wr_en && (wr_addr == 2'd1);
  wire start  = wr_cfg && wr_data[0] && !en_q;
  wire step   = en_q && sample_stb;

  logic [7:0]        res_sh, out_sh;
  logic [CNT_W-1:0]  last;
  logic [ACC_W-1:0]  int1_n, int2_n, comb1, comb2, scaled, full, sat;
  logic [DATA_W-1:0] data_n;

  assign res_sh = 8'(WIN_LG) + 8'(rate_q);
  assign out_sh = 8'(DATA_W) - res_sh;
  assign last   = (CNT_W'(1) << res_sh) - CNT_W'(1);
  assign int1_n = int1_q + ACC_W'(bit_in);
  assign int2_n = int2_q + int1_n;
  assign comb1  = int2_n - dly1_q;
  assign comb2  = comb1 - dly2_q;
  assign scaled = comb2 >> res_sh;
  assign full   = (ACC_W'(1) << res_sh) - ACC_W'(1);
  assign sat    = (scaled > full) ? full : scaled;
  assign data_n = DATA_W'(sat) << out_sh;

  wire done = step && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rate_q <= '0; sel_q <= '0;
      flag_q <= 1'b0; mask_q <= 1'b0;
      inval_q <= 1'b0; seen_one_q <= 1'b0;
      cnt_q <= '0; data_q <= '0;
      int1_q <= '0; int2_q <= '0; dly1_q <= '0; dly2_q <= '0;
    end else begin
      if (wr_cfg) begin
        en_q <= wr_data[0];
        if (!en_q) begin
          rate_q <= wr_data[RATE_LO +: RATE_W];
          sel_q  <= wr_data[SEL_LO +: SEL_W];
        end
      end
      if (start) begin
        cnt_q <= '0;
        int1_q <= '0; int2_q <= '0; dly1_q <= '0; dly2_q <= '0;
        inval_q <= 1'b1;
        seen_one_q <= 1'b0;
      end else if (step) begin
        int1_q <= int1_n;
        int2_q <= int2_n;
        cnt_q  <= done ? '0 : cnt_q + CNT_W'(1);
        if (done) begin
          dly1_q <= int2_n;
          dly2_q <= comb1;
          data_q <= data_n;
          seen_one_q <= 1'b1;
          if (seen_one_q) inval_q <= 1'b0;
        end
      end
      if (done) flag_q <= 1'b1;
      else if (wr_irq && wr_data[0]) flag_q <= 1'b0;
      if (wr_irq) mask_q <= wr_data[1];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      2'd0: begin
        rd_data[0] = en_q;
        rd_data[RATE_LO +: RATE_W] = rate_q;
        rd_data[SEL_LO +: SEL_W] = sel_q;
      end
      2'd1: begin
        rd_data[0] = flag_q;
        rd_data[1] = mask_q;
      end
      2'd2: rd_data = data_q;
      default: rd_data[0] = inval_q;
    endcase
  end

  assign irq      = flag_q && mask_q;
  assign amux_sel = sel_q;
endmodule

module sdm_decim_ctrl_chk #(
  parameter int WIN_LG = 5,
  parameter int RATE_W = 3,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_req,
  input logic              done,
  input logic              en_q,
  input logic              flag_q,
  input logic              inval_q,
  input logic              seen_one_q,
  input logic [RATE_W-1:0] rate_q,
  input logic [DATA_W-1:0] data_q,
  input logic [SEL_W-1:0]  amux_sel
);
  logic [DATA_W-1:0] low_mask;
  assign low_mask = (DATA_W'(1) << (DATA_W - WIN_LG - int'(rate_q))) - DATA_W'(1);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_req |=> flag_q);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !done |=> !flag_q);
  a_r7_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(amux_sel));
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (data_q & low_mask) == '0);
  a_r6_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done && seen_one_q |=> !inval_q);
endmodule

bind sdm_decim_ctrl sdm_decim_ctrl_chk #(
  .WIN_LG(WIN_LG), .RATE_W(RATE_W), .SEL_W(SEL_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .clr_req(wr_en && (wr_addr == 2'd1) && wr_data[0]),
  .done(done), .en_q(en_q), .flag_q(flag_q), .inval_q(inval_q),
  .seen_one_q(seen_one_q), .rate_q(rate_q), .data_q(data_q),
  .amux_sel(amux_sel)
);

// File: tb/sdm_decim_ctrl_tb.sv
module sdm_decim_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0, bit_in = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] rd_data;
  logic irq;
  logic [3:0] amux_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdm_decim_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .bit_in(bit_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .amux_sel(amux_sel)
  );

  int nchk = 0, nbad = 0;
  int ph = 0, tick_cnt = 0, pat_idx = 0;
  logic [31:0] pat = '0;
  bit en_b = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit allow = 1);
    @(negedge clk);
    wr_en = 1'b0;
    ph++;
    sample_stb = allow && (ph % 4 == 0);
    if (sample_stb) begin
      bit_in = pat[pat_idx];
      pat_idx = (pat_idx + 1) % 32;
      tick_cnt++;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(0);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 2'd0) begin
      if (!en_b && d[0]) begin tick_cnt = 0; pat_idx = 0; end
      en_b = d[0];
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_done(output int t);
    int guard = 0;
    do begin cyc(); guard++; end while (!irq && guard < 40000);
    t = tick_cnt;
  endtask

  function automatic logic [15:0] exp_data(input int rate, input int k);
    int v = k << rate;
    int fs = (1 << (5 + rate)) - 1;
    if (v > fs) v = fs;
    return 16'(v << (11 - rate));
  endfunction

  task automatic make_pat(input int k);
    pat = (k >= 32) ? 32'hFFFF_FFFF : ((32'd1 << k) - 32'd1);
    for (int s = 0; s < 64; s++) begin
      int i = $urandom % 32;
      int j = $urandom % 32;
      logic b = pat[i];
      pat[i] = pat[j];
      pat[j] = b;
    end
  endtask

  task automatic run_conv(input int rate, input int sel, input int k, input int nconv);
    int t, n;
    logic [15:0] v;
    n = 32 << rate;
    make_pat(k);
    wr(2'd1, 8'h03);
    wr(2'd0, {4'(sel), 3'(rate), 1'b1});
    for (int c = 1; c <= nconv; c++) begin
      wait_done(t);
      check("R2 completion strobe index", t, c * n);
      rd(2'd3, v);
      check("R6 invalid status bit", {31'd0, v[0]}, (c == 1) ? 32'd1 : 32'd0);
      if (c >= 2) begin
        rd(2'd2, v);
        if (k >= 32) check("R4 saturated result", v, exp_data(rate, k));
        else         check("R3 scaled result", v, exp_data(rate, k));
      end
      check("R7 mux select output", amux_sel, sel);
      wr(2'd1, 8'h03);
    end
    wr(2'd0, {4'(sel), 3'(rate), 1'b0});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int t;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register reset value", v, 0);
    end
    check("R1 irq reset", irq, 0);
    check("R1 mux select reset", amux_sel, 0);

    run_conv(0, 3, 0, 3);
    run_conv(0, 8, 32, 3);
    run_conv(3, 10, 32, 2);
    run_conv(7, 1, 13, 2);
    for (int r = 0; r < 6; r++)
      run_conv($urandom % 5, $urandom % 11, $urandom % 33, 2);

    // R5: clear and completion on the same edge, then mask gating
    make_pat(5);
    wr(2'd1, 8'h03);
    wr(2'd0, {4'd5, 3'd0, 1'b1});
    wait_done(t);
    wr(2'd1, 8'h03);
    do cyc(); while (tick_cnt < 64);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h03;
    cyc();
    rd(2'd1, v);
    check("R5 completion beats clear", {31'd0, v[0]}, 1);
    check("R5 irq after same-cycle clear", irq, 1);
    wr(2'd1, 8'h03);
    cyc();
    rd(2'd1, v);
    check("R5 write-one clears flag", {31'd0, v[0]}, 0);
    wr(2'd1, 8'h00);
    do cyc(); while (tick_cnt < 96);
    cyc();
    check("R5 masked irq low", irq, 0);
    rd(2'd1, v);
    check("R5 flag set while masked", {31'd0, v[0]}, 1);
    wr(2'd1, 8'h02);
    cyc();
    check("R5 irq after unmask", irq, 1);

    // R7: config writes ignored while enabled, disable stops
    wr(2'd0, {4'd9, 3'd3, 1'b1});
    cyc();
    check("R7 select frozen while enabled", amux_sel, 5);
    rd(2'd0, v);
    check("R7 rate frozen while enabled", v[7:0], {4'd5, 3'd0, 1'b1});
    wr(2'd0, {4'd5, 3'd0, 1'b0});
    wr(2'd1, 8'h03);
    repeat (4 * 100) cyc();
    rd(2'd1, v);
    check("R7 no completion after disable", {31'd0, v[0]}, 0);
    wr(2'd0, {4'd9, 3'd3, 1'b0});
    cyc();
    check("R7 select accepted while disabled", amux_sel, 9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule